// File: doc/BRIEF.md
# Multi-Channel Fault Qualification and Latch

This block sits between the raw diagnostic comparators of a bank of power switches and the serial status read path. Each channel feeds in four indications: an off-state open-load flag, a short flag, an overcurrent flag and an overtemperature flag. With them come the channel's commanded on/off state and whether its open-load sense current is switched on. The block turns these into one sticky fault bit per channel, ready for the next status frame.

Each raw indication first passes through a synchronizer. It then goes through qualification rules that depend on the command state and the sense-current enable. A settling window hides switching transients: a command update starts it and any later update restarts it. No fault can be latched while the window is open. A latched bit stays set after its condition goes away. The bit clears only when the frame logic captures the status word, and the next qualified detection sets it again.

The window length is a parameter counted in clock cycles. Its default is 200 µs at a 100 MHz clock, which is 20000 cycles. The synchronizer depth is also a parameter.

Top module: `fault_filter_latch`

## Requirements
- R1: While rst_ni is low, and after it is released with no stimulus, fault_o is all zeros and blank_o is 0.
- R2: blank_o is 1 in the cycle cmd_update_i is high and for BLANK_CYCLES cycles after it. No fault bit goes from 0 to 1 while blank_o is 1. A detection still present after the window ends is latched.
- R3: A cmd_update_i pulse during an open window restarts it, so blank_o stays high for BLANK_CYCLES cycles after the later pulse.
- R4: An open-load flag sets fault bit i only when channel i is commanded off (cmd_on_i[i]=0) and its sense current is enabled (ol_en_i[i]=1). With ol_en_i[i]=0 it leaves the bit at 0.
- R5: An open-load flag on a channel commanded on (cmd_on_i[i]=1) never sets its fault bit.
- R6: A short flag on a channel commanded off sets its fault bit whatever ol_en_i is. An overcurrent flag sets its fault bit whatever cmd_on_i and ol_en_i are.
- R7: An overtemperature flag sets its channel's fault bit whatever cmd_on_i and ol_en_i are.
- R8: A set fault bit stays 1 after its raw flag drops, until capture_i is asserted.
- R9: capture_i clears every fault bit that has no qualified detection in the same cycle. A bit with a qualified detection in that cycle stays or becomes 1.
- R10: Bit i of fault_o depends only on the inputs of channel i (bit i of each vector).
- R11: A steady raw flag outside the window first shows on fault_o after SYNC_STAGES+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_update_i | input | 1 | One-cycle pulse when a new command word is applied |
| capture_i | input | 1 | One-cycle pulse when the status word is taken at frame start |
| cmd_on_i | input | N_CH | Commanded state per channel, 1 = on |
| ol_en_i | input | N_CH | Open-load sense current enable per channel, 1 = enabled |
| open_raw_i | input | N_CH | Raw off-state open-load flag per channel (asynchronous) |
| short_raw_i | input | N_CH | Raw off-state short flag per channel (asynchronous) |
| ovc_raw_i | input | N_CH | Raw overcurrent flag per channel (asynchronous) |
| ot_raw_i | input | N_CH | Raw overtemperature flag per channel (asynchronous) |
| fault_o | output | N_CH | Latched fault bits, 1 = fault |
| blank_o | output | 1 | Settling window active |

## Verification
The bench measures the exact length of the window in cycles, both from a single update and from an update that lands halfway through a window. An off-by-one counter, or a timer that ignores a second update, gives a different count. It holds an overtemperature flag across an update and checks that the bit stays clear inside the window and is latched after it. A filter that samples during the window would set the bit early. Capture is applied while an overcurrent flag is still present: a design that gives clear priority over detection would drop a live fault for one whole frame. The vector table mixes commanded states and sense-current enables per channel, so that wrong gating of open-load flags, or one channel leaking into another, shows up as wrong bits.

// File: rtl/fflt_pkg.sv
package fflt_pkg;

  localparam int unsigned DEF_CLK_MHZ  = 100;
  localparam int unsigned DEF_BLANK_US = 200;

  function automatic int unsigned blank_cycles(int unsigned clk_mhz, int unsigned win_us);
    return clk_mhz * win_us;
  endfunction

  // synchronized detector set of one channel
  typedef struct packed {
    logic open;
    logic shrt;
    logic ovc;
    logic ot;
  } det_t;

endpackage

// File: rtl/fflt_sync.sv
module fflt_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned NST = (STAGES < 1) ? 1 : STAGES;

  logic [WIDTH-1:0] stg_q [NST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NST; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < NST; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[NST-1];

endmodule

// File: rtl/fflt_blank_timer.sv
module fflt_blank_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic update_i,
  output logic blank_o
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (update_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  // window covers the update cycle itself
  assign blank_o = update_i | (cnt_q != '0);

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (cnt_q == LOAD));

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && cnt_q == '0) |=> (cnt_q == '0));

  p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);

endmodule

// File: rtl/fflt_chan.sv
module fflt_chan
  import fflt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  det_t det_i,
  input  logic cmd_on_i,
  input  logic ol_en_i,
  input  logic blank_i,
  input  logic capture_i,
  output logic fault_o
);

  logic hit, qual, fault_q;

  // open-load counts only when off with sense current on
  assign hit  = (~cmd_on_i & det_i.open & ol_en_i)
              | (~cmd_on_i & det_i.shrt)
              | det_i.ovc
              | det_i.ot;
  assign qual = hit & ~blank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fault_q <= 1'b0;
    else if (capture_i) fault_q <= qual;
    else                fault_q <= fault_q | qual;
  end

  assign fault_o = fault_q;

  p_hold_in_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !capture_i) |=> (fault_q == $past(fault_q)));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && fault_q) |=> fault_q);

  p_ol_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !cmd_on_i && !ol_en_i && !det_i.shrt && !det_i.ovc && !det_i.ot) |=> !fault_q);

  p_on_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && cmd_on_i && !det_i.ovc && !det_i.ot) |=> !fault_q);

  p_ot_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i.ot && !blank_i) |=> fault_q);

  p_capture_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && det_i.ovc && !blank_i) |=> fault_q);

endmodule

// File: rtl/fault_filter_latch.sv
module fault_filter_latch
  import fflt_pkg::*;
#(
  parameter int unsigned N_CH         = 8,
  parameter int unsigned BLANK_CYCLES = blank_cycles(DEF_CLK_MHZ, DEF_BLANK_US),
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_update_i,
  input  logic            capture_i,
  input  logic [N_CH-1:0] cmd_on_i,
  input  logic [N_CH-1:0] ol_en_i,
  input  logic [N_CH-1:0] open_raw_i,
  input  logic [N_CH-1:0] short_raw_i,
  input  logic [N_CH-1:0] ovc_raw_i,
  input  logic [N_CH-1:0] ot_raw_i,
  output logic [N_CH-1:0] fault_o,
  output logic            blank_o
);

  localparam int unsigned SW = 4 * N_CH;

  logic [SW-1:0]   raw_s;
  logic [N_CH-1:0] open_s, short_s, ovc_s, ot_s;
  logic            blank;

  fflt_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({open_raw_i, short_raw_i, ovc_raw_i, ot_raw_i}),
    .q_o    (raw_s)
  );

  assign {open_s, short_s, ovc_s, ot_s} = raw_s;

  fflt_blank_timer #(.CYCLES(BLANK_CYCLES)) u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (cmd_update_i),
    .blank_o  (blank)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    det_t det;
    assign det = '{open: open_s[g], shrt: short_s[g], ovc: ovc_s[g], ot: ot_s[g]};

    fflt_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .det_i     (det),
      .cmd_on_i  (cmd_on_i[g]),
      .ol_en_i   (ol_en_i[g]),
      .blank_i   (blank),
      .capture_i (capture_i),
      .fault_o   (fault_o[g])
    );
  end

  assign blank_o = blank;

  p_no_rise_in_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && !capture_i) |=> ((fault_o & ~$past(fault_o)) == '0));

  p_no_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> (($past(fault_o) & ~fault_o) == '0));

  p_capture_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && blank_o) |=> (fault_o == '0));

  p_update_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_update_i |-> blank_o);

endmodule

// File: tb/fault_filter_latch_bench.sv
module fault_filter_latch_bench;

  localparam int N  = 8;
  localparam int BL = 16;
  localparam int SS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         upd, cap;
  logic [N-1:0] on, ol, op, sh, oc, ot;
  logic [N-1:0] fault;
  logic         blank;

  fault_filter_latch #(.N_CH(N), .BLANK_CYCLES(BL), .SYNC_STAGES(SS)) u_fault_filter_latch (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_update_i (upd),
    .capture_i    (cap),
    .cmd_on_i     (on),
    .ol_en_i      (ol),
    .open_raw_i   (op),
    .short_raw_i  (sh),
    .ovc_raw_i    (oc),
    .ot_raw_i     (ot),
    .fault_o      (fault),
    .blank_o      (blank)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // {on, ol, open, short, ovc, ot, expected}
  localparam logic [55:0] VEC [8] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h3C},
    {8'h0F, 8'hF0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hF0},
    {8'hAA, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 8'h81},
    {8'h55, 8'h33, 8'h0F, 8'hC0, 8'h02, 8'h00, 8'h82}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1, 5: return "R4";
      2:       return "R5";
      3, 4:    return "R6";
      6:       return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_upd();
    upd = 1'b1; tick(1); upd = 1'b0;
  endtask

  task automatic pulse_cap();
    cap = 1'b1; tick(1); cap = 1'b0;
  endtask

  task automatic raw_clear();
    op = '0; sh = '0; oc = '0; ot = '0;
  endtask

  task automatic count_blank(output int n);
    n = 0;
    upd = 1'b1;
    #1 if (blank) n++;
    @(negedge clk);
    upd = 1'b0;
    repeat (BL + 4) begin
      #1 if (blank) n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; upd = 1'b0; cap = 1'b0;
    on = '0; ol = '0; raw_clear();
    tick(3);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset blank", blank, 0);
    rst_n = 1'b1;
    tick(SS + 3);
    chk("R1 idle fault", fault, 0);
    chk("R1 idle blank", blank, 0);

    for (int i = 0; i < 8; i++) begin
      logic [55:0] v;
      v  = VEC[i];
      on = v[55:48]; ol = v[47:40];
      raw_clear();
      pulse_upd();
      tick(BL + 2);
      pulse_cap();
      tick(1);
      chk("R9 clear before vector", fault, 0);
      op = v[39:32]; sh = v[31:24]; oc = v[23:16]; ot = v[15:8];
      tick(SS + 2);
      chk(vec_req(i), fault, v[7:0]);
      raw_clear();
      tick(SS + 2);
      chk("R8 sticky", fault, v[7:0]);
      pulse_cap();
      tick(1);
      chk("R9 capture clears", fault, 0);
    end

    // R2 window length
    on = '0; ol = '0; raw_clear();
    tick(BL + 2);
    count_blank(n);
    chk("R2 window cycles", n, BL + 1);

    // R3 restart mid-window
    pulse_upd();
    tick(BL / 2);
    count_blank(n);
    chk("R3 restart cycles", n, BL + 1);
    tick(2);

    // R2 suppression inside window, latch after it
    pulse_cap();
    ot = 8'h01; upd = 1'b1;
    tick(1); upd = 1'b0;
    tick(BL - 2);
    chk("R2 blanked", fault, 0);
    tick(SS + 4);
    chk("R2 after window", fault, 8'h01);
    raw_clear();
    tick(SS + 2);
    pulse_cap();
    tick(1);
    chk("R9 clear", fault, 0);

    // R9 detection in capture cycle survives
    oc = 8'h02;
    tick(SS + 2);
    chk("R6 ovc", fault, 8'h02);
    pulse_cap();
    chk("R9 kept on capture", fault, 8'h02);
    raw_clear();
    tick(SS + 2);
    pulse_cap();
    chk("R9 cleared", fault, 0);

    // R11 latency
    sh = 8'h04;
    tick(SS);
    chk("R11 not yet", fault, 0);
    tick(1);
    chk("R11 arrived", fault, 8'h04);

    // R1 reset mid-run
    rst_n = 1'b0;
    tick(1);
    chk("R1 async clear", fault, 0);
    raw_clear();
    rst_n = 1'b1;
    tick(SS + 2);
    chk("R1 after release", fault, 0);

    finish_run();
  end

endmodule